// File: doc/BRIEF.md
# FM Synthesizer Host Register Front End

This block sits between a host bus and the datapath of a two-bank, four-operator FM synthesizer. The host issues byte writes on two logical ports, an address port and a data port, each available in two banks. The block spots each newly arrived write strobe, keeps the last accepted register address, and turns every following data byte into decoded control fields for the synthesis datapath. Those fields are per-operator slot settings, key-on requests, timer periods and modes, low-frequency oscillator control and direct sample output.

After every data write the block raises a busy flag for a fixed number of clocks, so the host can pace its accesses. The datapath reads slot settings through a combinational slot read port indexed by slot number. Writes are never refused or stalled. The host port has no back-pressure, and busy is only advisory: a write made while busy is high is still taken.

Top module: `fm_reg_frontend`

## Requirements
- R1: A write is a strobe on `wr_en` with `wr_port` and `wr_data`. `wr_port[0]`=0 selects the address port and `wr_port[0]`=1 selects the data port. `wr_port[1]` is the bank and becomes bit 8 of the captured 9-bit word `{wr_port[1], wr_data}`.
- R2: A port's strobe counts as a write only in the first cycle it is sampled high after being sampled low. Holding `wr_en` for several cycles gives one write. The write's effect is visible after the second rising edge counted from the edge that first samples the strobe.
- R3: Every recognised data write drives `busy` high for exactly 32 (BUSY_CYCLES) clock cycles, starting at the edge that applies the write. A data write recognised while busy restarts the 32-cycle window. This holds whether or not the address was accepted.
- R4: An address write whose bits 7:4 are zero is rejected. Data writes after it change no register until an address with nonzero bits 7:4 is written.
- R5: Slot index = 6*addr[3:2] + 3*addr[8] + addr[1:0], giving slots 0..23. addr[1:0]=3 selects no slot. A `rd_slot` value of 24 or more reads all zeros.
- R6: Slot pages are selected by address bits 7:4:
  - 3: detune = d[6:4], multiplier = d[3:0].
  - 4: total level = d[6:0].
  - 5: key scale = d[7:6], attack = d[4:0].
  - 6: AM = d[7], decay = d[4:0].
  - 8: sustain = d[7:4], release = d[3:0].
  - Any other page leaves slots unchanged.
- R7: The stored sustain level is 5 bits. Bit 4 is set only when d[7:4] = 15, so 15 reads back as 31 and every other value reads back unchanged.
- R8: A write to bank-0 register 0x28 sets `key_ops` = d[7:4]. If d[1:0] is not 3, it sets `key_ch` = d[1:0] + 3*d[2] and `key_ch_ok` = 1. If d[1:0] = 3, it sets `key_ch` = 0 and `key_ch_ok` = 0.
- R9: `tmr_a_period` is 10 bits. Bank-0 register 0x24 writes its bits 9:2 and register 0x25 writes its bits 1:0 from d[1:0]. `tmr_b_period` is written whole by register 0x26.
- R10: Bank-0 register 0x27 sets `ch3_mode` = d[7:6], `csm_on` = (d[7:6] = 2), `tmr_a_run` = d[0] and `tmr_b_run` = d[3]. When d[5] = 1, `tmr_b_clr` pulses high for exactly one cycle.
- R11: Bank-0 register 0x22 sets `lfo_on` = d[3] and `lfo_rate` = d[2:0]. Register 0x2A sets `dac_word` = {d, 1'b0}. Register 0x2B sets `dac_on` = d[7]. Global registers written through bank 1 have no effect.
- R12: After reset, every output is zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_port | input | 2 | Bit 0: data/address select; bit 1: bank |
| wr_data | input | 8 | Host write byte |
| busy | output | 1 | High for BUSY_CYCLES after each data write |
| rd_slot | input | 5 | Slot index for the read port |
| rd_detune | output | 3 | Detune of selected slot |
| rd_mult | output | 4 | Multiplier of selected slot |
| rd_tl | output | 7 | Total level of selected slot |
| rd_ks | output | 2 | Key scale of selected slot |
| rd_attack | output | 5 | Attack rate of selected slot |
| rd_am | output | 1 | AM enable of selected slot |
| rd_decay | output | 5 | Decay rate of selected slot |
| rd_sus | output | 5 | Expanded sustain level of selected slot |
| rd_rel | output | 4 | Release rate of selected slot |
| lfo_on | output | 1 | LFO enable |
| lfo_rate | output | 3 | LFO rate select |
| tmr_a_period | output | 10 | Timer A reload value |
| tmr_b_period | output | 8 | Timer B reload value |
| ch3_mode | output | 2 | Channel-3 mode field |
| csm_on | output | 1 | Composite sine mode active |
| tmr_a_run | output | 1 | Timer A load/run |
| tmr_b_run | output | 1 | Timer B enable |
| tmr_b_clr | output | 1 | One-cycle timer B clear pulse |
| key_ops | output | 4 | Operator key-on mask |
| key_ch | output | 3 | Key-on channel 0..5 |
| key_ch_ok | output | 1 | Key-on channel valid |
| dac_on | output | 1 | Direct sample output enable |
| dac_word | output | 9 | Direct sample value |

## Verification
A wrong edge-history bit shows up at once. Either a held strobe is applied twice, which stretches `busy` past 32 cycles and re-pulses `tmr_b_clr`, or a fresh strobe is missed and a register keeps its old value two edges after the write. A stuck busy counter turns into a wrong busy length within 33 cycles. A corrupted address latch or slot index shows as a field landing in the wrong slot, which the sweep of the slot read port reaches within 32 cycles. The bench compares every output against a behavioural model on every clock, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/fmr_pkg.sv
`timescale 1ns/1ps
package fmr_pkg;
  // per-slot settings as stored and as read back
  typedef struct packed {
    logic [2:0] dt;
    logic [3:0] mul;
    logic [6:0] tl;
    logic [1:0] ks;
    logic [4:0] ar;
    logic       am;
    logic [4:0] dr;
    logic [4:0] sl;
    logic [3:0] rr;
  } slot_cfg_t;

  // slot register pages (address bits 7:4)
  localparam logic [3:0] PG_TUNE  = 4'h3;
  localparam logic [3:0] PG_LEVEL = 4'h4;
  localparam logic [3:0] PG_ATK   = 4'h5;
  localparam logic [3:0] PG_DEC   = 4'h6;
  localparam logic [3:0] PG_REL   = 4'h8;

  // global register numbers (bank 0)
  localparam logic [7:0] GA_LFO   = 8'h22;
  localparam logic [7:0] GA_TA_HI = 8'h24;
  localparam logic [7:0] GA_TA_LO = 8'h25;
  localparam logic [7:0] GA_TB    = 8'h26;
  localparam logic [7:0] GA_MODE  = 8'h27;
  localparam logic [7:0] GA_KEY   = 8'h28;
  localparam logic [7:0] GA_DAC   = 8'h2A;
  localparam logic [7:0] GA_DACEN = 8'h2B;
endpackage

// File: rtl/fmr_wr_capture.sv
`timescale 1ns/1ps
module fmr_wr_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_port,
  input  logic [DW-1:0] wr_data,
  output logic          a_en,
  output logic          d_en,
  output logic [DW:0]   word
);
  logic [1:0] hist_a, hist_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_a <= '0;
      hist_d <= '0;
      word   <= '0;
    end else begin
      hist_a <= {hist_a[0], wr_en & ~wr_port[0]};
      hist_d <= {hist_d[0], wr_en &  wr_port[0]};
      if (wr_en) word <= {wr_port[1], wr_data};
    end
  end

  assign a_en = (hist_a == 2'b01);
  assign d_en = (hist_d == 2'b01);

  AST_A_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    a_en |=> !a_en); // R2
  AST_D_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    d_en |=> !d_en); // R2
endmodule

// File: rtl/fmr_busy.sv
`timescale 1ns/1ps
module fmr_busy #(
  parameter int BUSY_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R3
  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy); // R3
endmodule

// File: rtl/fmr_glob_regs.sv
`timescale 1ns/1ps
module fmr_glob_regs
  import fmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_go,
  input  logic [8:0] addr,
  input  logic [7:0] din,
  output logic       lfo_on,
  output logic [2:0] lfo_rate,
  output logic [9:0] tmr_a_period,
  output logic [7:0] tmr_b_period,
  output logic [1:0] ch3_mode,
  output logic       csm_on,
  output logic       tmr_a_run,
  output logic       tmr_b_run,
  output logic       tmr_b_clr,
  output logic [3:0] key_ops,
  output logic [2:0] key_ch,
  output logic       key_ch_ok,
  output logic       dac_on,
  output logic [8:0] dac_word
);
  logic       hit;
  logic [7:0] dac_hi;

  assign hit      = wr_go && !addr[8];
  assign dac_word = {dac_hi, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfo_on       <= 1'b0;
      lfo_rate     <= '0;
      tmr_a_period <= '0;
      tmr_b_period <= '0;
      ch3_mode     <= '0;
      csm_on       <= 1'b0;
      tmr_a_run    <= 1'b0;
      tmr_b_run    <= 1'b0;
      tmr_b_clr    <= 1'b0;
      key_ops      <= '0;
      key_ch       <= '0;
      key_ch_ok    <= 1'b0;
      dac_on       <= 1'b0;
      dac_hi       <= '0;
    end else begin
      tmr_b_clr <= 1'b0;
      if (hit) begin
        case (addr[7:0])
          GA_LFO: begin
            lfo_on   <= din[3];
            lfo_rate <= din[2:0];
          end
          GA_TA_HI: tmr_a_period[9:2] <= din;
          GA_TA_LO: tmr_a_period[1:0] <= din[1:0];
          GA_TB:    tmr_b_period      <= din;
          GA_MODE: begin
            ch3_mode  <= din[7:6];
            csm_on    <= (din[7:6] == 2'd2);
            tmr_a_run <= din[0];
            tmr_b_run <= din[3];
            tmr_b_clr <= din[5];
          end
          GA_KEY: begin
            key_ops <= din[7:4];
            if (din[1:0] == 2'd3) begin
              key_ch    <= '0;
              key_ch_ok <= 1'b0;
            end else begin
              key_ch    <= {1'b0, din[1:0]} + (din[2] ? 3'd3 : 3'd0);
              key_ch_ok <= 1'b1;
            end
          end
          GA_DAC:   dac_hi <= din;
          GA_DACEN: dac_on <= din[7];
          default: ;
        endcase
      end
    end
  end

  AST_KEY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    key_ch_ok |-> (key_ch < 3'd6)); // R8
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_b_clr |=> !tmr_b_clr); // R10
  AST_CSM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    csm_on == (ch3_mode == 2'd2)); // R10
endmodule

// File: rtl/fmr_slot_bank.sv
`timescale 1ns/1ps
module fmr_slot_bank
  import fmr_pkg::*;
#(
  parameter int CH_PER_BANK = 3,
  parameter int NSLOT = 8 * CH_PER_BANK,
  parameter int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic [8:0]    addr,
  input  logic [7:0]    din,
  input  logic [SW-1:0] rd_slot,
  output slot_cfg_t     rd_cfg
);
  logic [3:0]       page;
  logic [1:0]       ch;
  logic             ch_ok;
  logic [SW-1:0]    widx;
  logic [NSLOT-1:0] hit;
  slot_cfg_t        cfg [NSLOT];

  always_comb begin
    page  = addr[7:4];
    ch    = addr[1:0];
    ch_ok = (int'(ch) < CH_PER_BANK);
    widx  = SW'(addr[3:2]) * SW'(2 * CH_PER_BANK)
          + (addr[8] ? SW'(CH_PER_BANK) : SW'(0))
          + SW'(ch);
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    slot_cfg_t r;
    assign hit[g] = wr_go && ch_ok && (widx == SW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r <= '0;
      end else if (hit[g]) begin
        case (page)
          PG_TUNE: begin
            r.dt  <= din[6:4];
            r.mul <= din[3:0];
          end
          PG_LEVEL: r.tl <= din[6:0];
          PG_ATK: begin
            r.ks <= din[7:6];
            r.ar <= din[4:0];
          end
          PG_DEC: begin
            r.am <= din[7];
            r.dr <= din[4:0];
          end
          PG_REL: begin
            r.sl <= {&din[7:4], din[7:4]};
            r.rr <= din[3:0];
          end
          default: ;
        endcase
      end
    end
    assign cfg[g] = r;
  end

  always_comb begin
    rd_cfg = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rd_slot == SW'(i)) rd_cfg = cfg[i];
    end
  end

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R5
  AST_SL_EXPAND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cfg.sl[4] |-> (rd_cfg.sl[3:0] == 4'hF)); // R7
endmodule

// File: rtl/fm_reg_frontend.sv
`timescale 1ns/1ps
module fm_reg_frontend
  import fmr_pkg::*;
#(
  parameter int BUSY_CYCLES = 32,
  parameter int CH_PER_BANK = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_port,
  input  logic [7:0] wr_data,
  output logic       busy,
  input  logic [$clog2(8*CH_PER_BANK)-1:0] rd_slot,
  output logic [2:0] rd_detune,
  output logic [3:0] rd_mult,
  output logic [6:0] rd_tl,
  output logic [1:0] rd_ks,
  output logic [4:0] rd_attack,
  output logic       rd_am,
  output logic [4:0] rd_decay,
  output logic [4:0] rd_sus,
  output logic [3:0] rd_rel,
  output logic       lfo_on,
  output logic [2:0] lfo_rate,
  output logic [9:0] tmr_a_period,
  output logic [7:0] tmr_b_period,
  output logic [1:0] ch3_mode,
  output logic       csm_on,
  output logic       tmr_a_run,
  output logic       tmr_b_run,
  output logic       tmr_b_clr,
  output logic [3:0] key_ops,
  output logic [2:0] key_ch,
  output logic       key_ch_ok,
  output logic       dac_on,
  output logic [8:0] dac_word
);
  localparam int NSLOT = 8 * CH_PER_BANK;
  localparam int SW    = $clog2(NSLOT);

  logic       a_en, d_en, addr_ok, wr_go;
  logic [8:0] word, addr_q;
  slot_cfg_t  rd_cfg;

  fmr_wr_capture #(.DW(8)) u_cap (
    .clk, .rst_n, .wr_en, .wr_port, .wr_data,
    .a_en, .d_en, .word
  );

  fmr_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk, .rst_n, .start(d_en), .busy
  );

  // address latch: only FM pages (nonzero upper nibble) are accepted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      addr_ok <= 1'b0;
    end else if (a_en) begin
      if (word[7:4] != 4'h0) begin
        addr_q  <= word;
        addr_ok <= 1'b1;
      end else begin
        addr_ok <= 1'b0;
      end
    end
  end

  assign wr_go = d_en && addr_ok;

  fmr_glob_regs u_glob (
    .clk, .rst_n, .wr_go, .addr(addr_q), .din(word[7:0]),
    .lfo_on, .lfo_rate, .tmr_a_period, .tmr_b_period,
    .ch3_mode, .csm_on, .tmr_a_run, .tmr_b_run, .tmr_b_clr,
    .key_ops, .key_ch, .key_ch_ok, .dac_on, .dac_word
  );

  fmr_slot_bank #(.CH_PER_BANK(CH_PER_BANK), .NSLOT(NSLOT), .SW(SW)) u_slots (
    .clk, .rst_n, .wr_go, .addr(addr_q), .din(word[7:0]),
    .rd_slot, .rd_cfg
  );

  assign rd_detune = rd_cfg.dt;
  assign rd_mult   = rd_cfg.mul;
  assign rd_tl     = rd_cfg.tl;
  assign rd_ks     = rd_cfg.ks;
  assign rd_attack = rd_cfg.ar;
  assign rd_am     = rd_cfg.am;
  assign rd_decay  = rd_cfg.dr;
  assign rd_sus    = rd_cfg.sl;
  assign rd_rel    = rd_cfg.rr;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && word[7:4] == 4'h0) |=> ($stable(addr_q) && !addr_ok)); // R4
  AST_NO_WRITE_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> !wr_go); // R4
endmodule

// File: tb/tb_fm_reg_frontend.sv
`timescale 1ns/1ps
module tb_fm_reg_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_port = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_slot = '0;
  logic busy, rd_am, lfo_on, csm_on, tmr_a_run, tmr_b_run, tmr_b_clr, key_ch_ok, dac_on;
  logic [2:0] rd_detune, lfo_rate, key_ch;
  logic [3:0] rd_mult, rd_rel, key_ops;
  logic [6:0] rd_tl;
  logic [1:0] rd_ks, ch3_mode;
  logic [4:0] rd_attack, rd_decay, rd_sus;
  logic [9:0] tmr_a_period;
  logic [7:0] tmr_b_period;
  logic [8:0] dac_word;

  fm_reg_frontend dut (.*);

  always #2 clk = ~clk; // 250 MHz

  int errs = 0, checks = 0;
  bit done = 0, sweep = 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_la, m_ld, m_pa, m_pd, m_word, m_addr, m_aok, m_busy, m_bcnt;
  int m_lfo_on, m_lfo_rate, m_ta, m_tb, m_mode, m_ta_run, m_tb_run, m_clr;
  int m_kops, m_kch, m_kok, m_dac_on, m_dac;
  int m_dt[24], m_mul[24], m_tl[24], m_ks[24], m_ar[24], m_am[24], m_dr[24], m_sl[24], m_rr[24];

  task automatic m_reset();
    m_la = 0; m_ld = 0; m_pa = 0; m_pd = 0; m_word = 0; m_addr = 0; m_aok = 0;
    m_busy = 0; m_bcnt = 0; m_lfo_on = 0; m_lfo_rate = 0; m_ta = 0; m_tb = 0;
    m_mode = 0; m_ta_run = 0; m_tb_run = 0; m_clr = 0; m_kops = 0; m_kch = 0;
    m_kok = 0; m_dac_on = 0; m_dac = 0;
    for (int i = 0; i < 24; i++) begin
      m_dt[i] = 0; m_mul[i] = 0; m_tl[i] = 0; m_ks[i] = 0; m_ar[i] = 0;
      m_am[i] = 0; m_dr[i] = 0; m_sl[i] = 0; m_rr[i] = 0;
    end
  endtask

  task automatic m_apply(input int a, input int d);
    int pg, c, s, bank;
    bank = (a >> 8) & 1;
    if (bank == 0) begin
      case (a & 255)
        'h22: begin m_lfo_on = (d >> 3) & 1; m_lfo_rate = d & 7; end
        'h24: m_ta = (m_ta & 3) | (d << 2);
        'h25: m_ta = (m_ta & 'h3FC) | (d & 3);
        'h26: m_tb = d;
        'h27: begin m_mode = (d >> 6) & 3; m_ta_run = d & 1; m_tb_run = (d >> 3) & 1; m_clr = (d >> 5) & 1; end
        'h28: begin
          m_kops = (d >> 4) & 15;
          if ((d & 3) == 3) begin m_kch = 0; m_kok = 0; end
          else begin m_kch = (d & 3) + 3 * ((d >> 2) & 1); m_kok = 1; end
        end
        'h2A: m_dac = d * 2;
        'h2B: m_dac_on = (d >> 7) & 1;
        default: ;
      endcase
    end
    pg = (a >> 4) & 15;
    c = a & 3;
    if (c != 3) begin
      s = ((a >> 2) & 3) * 6 + bank * 3 + c;
      case (pg)
        3: begin m_dt[s] = (d >> 4) & 7; m_mul[s] = d & 15; end
        4: m_tl[s] = d & 127;
        5: begin m_ks[s] = (d >> 6) & 3; m_ar[s] = d & 31; end
        6: begin m_am[s] = (d >> 7) & 1; m_dr[s] = d & 31; end
        8: begin m_sl[s] = ((d >> 4) == 15) ? 31 : (d >> 4); m_rr[s] = d & 15; end
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    int sa, sd;
    if (!rst_n) m_reset();
    else begin
      m_clr = 0;
      if (m_pd) begin m_busy = 1; m_bcnt = 0; end
      else if (m_busy) begin
        if (m_bcnt == 31) m_busy = 0;
        m_bcnt++;
      end
      if (m_pd && m_aok) m_apply(m_addr, m_word & 255);
      if (m_pa) begin
        if (((m_word >> 4) & 15) != 0) begin m_addr = m_word; m_aok = 1; end
        else m_aok = 0;
      end
      sa = (wr_en && !wr_port[0]) ? 1 : 0;
      sd = (wr_en &&  wr_port[0]) ? 1 : 0;
      m_pa = sa && !m_la; m_la = sa;
      m_pd = sd && !m_ld; m_ld = sd;
      if (wr_en) m_word = {23'd0, wr_port[1], wr_data};
    end
    if (sweep) rd_slot <= rd_slot + 5'd1;
  end

  // compare every output on every cycle, away from the active edge
  always @(negedge clk) begin
    int s;
    if (rst_n && !done) begin
      s = int'(rd_slot);
      chk("R3", "busy", busy, m_busy);
      chk("R11", "lfo_on", lfo_on, m_lfo_on);
      chk("R11", "lfo_rate", lfo_rate, m_lfo_rate);
      chk("R9", "tmr_a_period", tmr_a_period, m_ta);
      chk("R9", "tmr_b_period", tmr_b_period, m_tb);
      chk("R10", "ch3_mode", ch3_mode, m_mode);
      chk("R10", "csm_on", csm_on, m_mode == 2);
      chk("R10", "tmr_a_run", tmr_a_run, m_ta_run);
      chk("R10", "tmr_b_run", tmr_b_run, m_tb_run);
      chk("R10", "tmr_b_clr", tmr_b_clr, m_clr);
      chk("R8", "key_ops", key_ops, m_kops);
      chk("R8", "key_ch", key_ch, m_kch);
      chk("R8", "key_ch_ok", key_ch_ok, m_kok);
      chk("R11", "dac_on", dac_on, m_dac_on);
      chk("R11", "dac_word", dac_word, m_dac);
      chk("R6", "rd_detune", rd_detune, (s < 24) ? m_dt[s % 24] : 0);
      chk("R6", "rd_mult", rd_mult, (s < 24) ? m_mul[s % 24] : 0);
      chk("R6", "rd_tl", rd_tl, (s < 24) ? m_tl[s % 24] : 0);
      chk("R6", "rd_ks", rd_ks, (s < 24) ? m_ks[s % 24] : 0);
      chk("R6", "rd_attack", rd_attack, (s < 24) ? m_ar[s % 24] : 0);
      chk("R6", "rd_am", rd_am, (s < 24) ? m_am[s % 24] : 0);
      chk("R6", "rd_decay", rd_decay, (s < 24) ? m_dr[s % 24] : 0);
      chk("R7", "rd_sus", rd_sus, (s < 24) ? m_sl[s % 24] : 0);
      chk("R6", "rd_rel", rd_rel, (s < 24) ? m_rr[s % 24] : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic bank, input logic [7:0] a, input logic [7:0] d);
    wr({bank, 1'b0}, a);
    wr({bank, 1'b1}, d);
  endtask

  task automatic peek(input int s);
    sweep = 0;
    @(negedge clk); rd_slot = 5'(s);
    #1;
  endtask

  task automatic busy_run(input int hold, input int again, output int n);
    n = 0;
    @(negedge clk); wr_en = 1'b1; wr_port = 2'b01; wr_data = 8'h00;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (i == hold - 1) wr_en = 1'b0;
      if (again > 0 && i == again - 1) wr_en = 1'b1;
      if (again > 0 && i == again) wr_en = 1'b0;
      if (busy) n++;
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk("R12", "busy", busy, 0);
    chk("R12", "tmr_a_period", tmr_a_period, 0);
    chk("R12", "key_ch_ok", key_ch_ok, 0);
    chk("R12", "dac_word", dac_word, 0);

    // R9 timers
    reg_wr(0, 8'h24, 8'hAB);
    reg_wr(0, 8'h25, 8'h07);
    chk("R9", "timer A split", tmr_a_period, 'h2AF);
    reg_wr(0, 8'h26, 8'h5C);
    chk("R9", "timer B", tmr_b_period, 'h5C);

    // R10 mode register and clear pulse
    reg_wr(0, 8'h27, 8'hA9);
    chk("R10", "clr pulse high", tmr_b_clr, 1);
    chk("R10", "csm", csm_on, 1);
    chk("R10", "tb run", tmr_b_run, 1);
    @(negedge clk);
    chk("R10", "clr pulse low", tmr_b_clr, 0);
    reg_wr(0, 8'h27, 8'h40);
    chk("R10", "csm off mode1", {ch3_mode, csm_on}, 3'b010);

    // R8 key on
    reg_wr(0, 8'h28, 8'hF6);
    chk("R8", "key ops/ch", {key_ops, key_ch, key_ch_ok}, {4'hF, 3'd5, 1'b1});
    reg_wr(0, 8'h28, 8'h51);
    chk("R8", "key ch1", {key_ops, key_ch, key_ch_ok}, {4'h5, 3'd1, 1'b1});
    reg_wr(0, 8'h28, 8'h37);
    chk("R8", "key invalid", key_ch_ok, 0);

    // R11 LFO / DAC, and bank-1 global ignored
    reg_wr(0, 8'h22, 8'h0D);
    chk("R11", "lfo", {lfo_on, lfo_rate}, 4'hD);
    reg_wr(0, 8'h2A, 8'h81);
    chk("R11", "dac word", dac_word, 'h102);
    reg_wr(0, 8'h2B, 8'h80);
    chk("R11", "dac on", dac_on, 1);
    reg_wr(1, 8'h2B, 8'h00);
    chk("R11", "bank1 global ignored", dac_on, 1);

    // R5/R6/R7 slot decode (R1: bank bit from wr_port[1])
    reg_wr(1, 8'h3E, 8'h75);
    reg_wr(0, 8'h40, 8'h7F);
    reg_wr(0, 8'h85, 8'hF3);
    reg_wr(1, 8'h59, 8'hDF);
    reg_wr(0, 8'h62, 8'h9A);
    reg_wr(0, 8'h80, 8'h72);
    reg_wr(0, 8'h83, 8'h11);
    reg_wr(1, 8'h70, 8'hFF);
    peek(23); chk("R5", "slot23 dt/mul", {rd_detune, rd_mult}, {3'd7, 4'd5});
    peek(0);  chk("R6", "slot0 tl", rd_tl, 127);
    chk("R7", "slot0 sus 7", rd_sus, 7);
    peek(7);  chk("R7", "slot7 sus 15->31", rd_sus, 31);
    chk("R6", "slot7 rel", rd_rel, 3);
    peek(16); chk("R1", "bank1 slot16 ks/ar", {rd_ks, rd_attack}, {2'd3, 5'h1F});
    peek(2);  chk("R6", "slot2 am/dr", {rd_am, rd_decay}, {1'b1, 5'h1A});
    peek(3);  chk("R5", "ch3 code no slot", rd_rel, 0);
    peek(27); chk("R5", "out of range", rd_tl, 0);
    sweep = 1;

    // R4 rejected address blocks data
    reg_wr(0, 8'h06, 8'h11);
    chk("R4", "timer B unchanged", tmr_b_period, 'h5C);
    reg_wr(0, 8'h26, 8'h33);
    chk("R4", "timer B after valid addr", tmr_b_period, 'h33);

    // R3 / R2 busy timing
    wr(2'b00, 8'h70);
    repeat (40) @(negedge clk);
    busy_run(1, 0, n);
    chk("R3", "busy length", n, 32);
    busy_run(6, 0, n);
    chk("R2", "held strobe single write", n, 32);
    busy_run(1, 10, n);
    chk("R3", "retrigger length", n, 42);

    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      int sel;
      sel = int'($urandom % 12);
      case (sel)
        0: a = 8'h22; 1: a = 8'h24; 2: a = 8'h25; 3: a = 8'h27;
        4: a = 8'h28; 5: a = 8'h2A; 6: a = 8'h05;
        default: a = {4'(3 + ($urandom % 6)), 4'($urandom)};
      endcase
      @(negedge clk); wr_en = 1; wr_port = {1'($urandom), 1'b0}; wr_data = a;
      repeat (1 + $urandom % 2) @(negedge clk);
      wr_en = 0;
      repeat (1 + $urandom % 2) @(negedge clk);
      wr_en = 1; wr_port[0] = 1'b1; wr_data = 8'($urandom);
      repeat (1 + $urandom % 2) @(negedge clk);
      wr_en = 0;
      repeat (1 + $urandom % 3) @(negedge clk);
    end
    repeat (40) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule